// File: doc/BRIEF.md
# Two-Level Strided Address Generator

This block produces the byte address of the current element of a DMA block transfer, for one side of the transfer, either source or destination. The controller around it loads a start address, then pulses a step input for each element moved and marks the steps that cross a microblock boundary. The block adds the element size, and optionally a signed per-element stride or a signed per-microblock stride, to the held address. Counting elements and microblocks and driving the bus stay with the caller.

Four addressing modes are offered: a constant address, plain incrementing, microblock striding with contiguous elements, and striding at both the element and the microblock level. Strides are signed, so accesses can leave gaps, hold one location, walk downward, or replay and revisit earlier microblocks. One instance per side is enough to transpose or rotate a two-dimensional array in memory. For example, a 10x10 byte array written with start address 9, element stride 9 and microblock stride -92 comes out rotated a quarter turn clockwise.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset is released, addr_o reads 0 until the first load.
- R2: When load_i is high at a clock edge, addr_o equals start_addr_i from the next cycle on, even if elem_step_i or ublk_step_i is high in the same cycle.
- R3: With mode_i = 0 (fixed), steps leave addr_o unchanged.
- R4: With mode_i = 1 (incremented), each step adds the element size 2^width_i bytes (width_i 0..3 gives 1, 2, 4 or 8 bytes), whether or not it is a boundary step.
- R5: With mode_i = 2 (microblock stride), a step with ublk_step_i low adds the element size only, and a step with ublk_step_i high adds the element size plus ublk_stride_i; data_stride_i has no effect.
- R6: With mode_i = 3 (microblock and data stride), a step with ublk_step_i low adds the element size plus data_stride_i, and a step with ublk_step_i high adds the element size plus ublk_stride_i in place of the data stride.
- R7: With byte elements in mode 3, a data stride of -1 keeps addr_o on the same address over successive non-boundary steps.
- R8: With byte elements in mode 2 and microblocks of L elements, a microblock stride of -L returns the address to the first element of the same microblock, and -2L moves it to the start of the previous microblock.
- R9: Both strides are 24-bit two's-complement values sign-extended to 32 bits, and every addition wraps modulo 2^32.
- R10: A step is any cycle with elem_step_i or ublk_step_i high; with neither high and load_i low, addr_o holds.
- R11: In mode 3 with byte elements, start address 9, data stride 9 and microblock stride -92, the 100 successive addresses of ten 10-element microblocks are row*10 + (9 - microblock index), element index being the row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load start address (wins over steps) |
| start_addr_i | input | 32 | Start address of the block |
| width_i | input | 2 | log2 of element size in bytes |
| mode_i | input | 2 | 0 fixed, 1 incremented, 2 microblock stride, 3 microblock and data stride |
| data_stride_i | input | 24 | Signed gap between elements in bytes |
| ublk_stride_i | input | 24 | Signed gap between microblocks in bytes |
| elem_step_i | input | 1 | Advance to the next element |
| ublk_step_i | input | 1 | Advance that crosses a microblock boundary |
| addr_o | output | 32 | Current element address |

## Verification
The address register is the only state, so any wrong increment, sign extension or mode decode shows on addr_o one cycle after the step that caused it and then persists, since every later address builds on it. The rotation walk is the sharpest probe: an error in choosing between the two strides at a boundary shifts every remaining address of the array. Load priority and hold behaviour are seen directly as an address that moved when it should not have.

// File: rtl/stride_addr_pkg.sv
package stride_addr_pkg;
  typedef enum logic [1:0] {
    AM_FIXED  = 2'd0,
    AM_INCR   = 2'd1,
    AM_UBS    = 2'd2,
    AM_UBS_DS = 2'd3
  } addr_mode_e;
endpackage

// File: rtl/stride_addr_sext.sv
module stride_addr_sext #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  generate
    if (IN_W < OUT_W) begin : g_ext
      assign val_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
    end else begin : g_trunc
      assign val_o = val_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/stride_addr_rst_sync.sv
module stride_addr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/stride_addr_delta.sv
module stride_addr_delta
  import stride_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  addr_mode_e          mode_i,
  input  logic [SIZE_W-1:0]   width_i,
  input  logic [ADDR_W-1:0]   dstride_i,
  input  logic [ADDR_W-1:0]   ustride_i,
  input  logic                boundary_i,
  output logic [ADDR_W-1:0]   delta_o
);
  logic [ADDR_W-1:0] elem_size;
  logic [ADDR_W-1:0] ubs_extra;
  logic [ADDR_W-1:0] ds_extra;

  always_comb begin
    elem_size = ADDR_W'(1) << width_i;
    ubs_extra = boundary_i ? ustride_i : '0;
    ds_extra  = boundary_i ? ustride_i : dstride_i;
    case (mode_i)
      AM_FIXED:  delta_o = '0;
      AM_INCR:   delta_o = elem_size;
      AM_UBS:    delta_o = elem_size + ubs_extra;
      AM_UBS_DS: delta_o = elem_size + ds_extra;
      default:   delta_o = '0;
    endcase
  end
endmodule

// File: rtl/stride_addr_reg.sv
module stride_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] delta_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_i | advance_i;
    if (load_i) addr_d = start_i;
    else        addr_d = addr_q + delta_i;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    load_i |=> (addr_o == $past(start_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load_i && !advance_i) |=> $stable(addr_o));
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
  import stride_addr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 24,
  parameter int SIZE_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   start_addr_i,
  input  logic [SIZE_W-1:0]   width_i,
  input  logic [1:0]          mode_i,
  input  logic [STRIDE_W-1:0] data_stride_i,
  input  logic [STRIDE_W-1:0] ublk_stride_i,
  input  logic                elem_step_i,
  input  logic                ublk_step_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic              rst_ok;
  logic [ADDR_W-1:0] dstride_ext;
  logic [ADDR_W-1:0] ustride_ext;
  logic [ADDR_W-1:0] delta;
  logic              advance;
  addr_mode_e        mode;

  assign mode    = addr_mode_e'(mode_i);
  assign advance = elem_step_i | ublk_step_i;

  stride_addr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  stride_addr_sext #(.IN_W(STRIDE_W), .OUT_W(ADDR_W)) u_dsext (
    .val_i(data_stride_i), .val_o(dstride_ext)
  );

  stride_addr_sext #(.IN_W(STRIDE_W), .OUT_W(ADDR_W)) u_usext (
    .val_i(ublk_stride_i), .val_o(ustride_ext)
  );

  stride_addr_delta #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_delta (
    .mode_i(mode), .width_i(width_i), .dstride_i(dstride_ext),
    .ustride_i(ustride_ext), .boundary_i(ublk_step_i), .delta_o(delta)
  );

  stride_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst_ok(rst_ok), .load_i(load_i), .start_i(start_addr_i),
    .advance_i(advance), .delta_i(delta), .addr_o(addr_o)
  );

  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i == 2'd0 && !load_i) |=> $stable(addr_o));

  // R4
  incr_size_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i == 2'd1 && !load_i && advance) |=>
      (addr_o == $past(addr_o) + (ADDR_W'(1) << $past(width_i))));

  // R7
  minus_one_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i == 2'd3 && width_i == '0 && data_stride_i == '1 &&
     elem_step_i && !ublk_step_i && !load_i) |=> $stable(addr_o));
endmodule

// File: tb/stride_addr_gen_bench.sv
`timescale 1ns/1ps
module stride_addr_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [31:0] start_addr_i;
  logic [1:0]  width_i;
  logic [1:0]  mode_i;
  logic [23:0] data_stride_i;
  logic [23:0] ublk_stride_i;
  logic        elem_step_i;
  logic        ublk_step_i;
  logic [31:0] addr_o;

  int n_run;
  int n_fail;
  bit done;

  stride_addr_gen u_stride_addr_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .width_i(width_i), .mode_i(mode_i), .data_stride_i(data_stride_i),
    .ublk_stride_i(ublk_stride_i), .elem_step_i(elem_step_i),
    .ublk_step_i(ublk_step_i), .addr_o(addr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] exp);
    n_run++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [1:0] w,
                     input logic [23:0] ds, input logic [23:0] us);
    @(negedge clk);
    mode_i = m; width_i = w; data_stride_i = ds; ublk_stride_i = us;
  endtask

  task automatic do_load(input logic [31:0] a, input logic e, input logic u);
    @(negedge clk);
    start_addr_i = a; load_i = 1'b1; elem_step_i = e; ublk_step_i = u;
    @(posedge clk); #1;
    load_i = 1'b0; elem_step_i = 1'b0; ublk_step_i = 1'b0;
  endtask

  task automatic do_step(input logic u);
    @(negedge clk);
    elem_step_i = 1'b1; ublk_step_i = u;
    @(posedge clk); #1;
    elem_step_i = 1'b0; ublk_step_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset value", 32'h0);
  endtask

  task automatic t_load_priority();
    cfg(2'd1, 2'd2, 24'd0, 24'd0);
    do_load(32'h0000_1000, 1'b1, 1'b1);
    chk("R2 load over step", 32'h0000_1000);
    do_load(32'h0000_2468, 1'b0, 1'b0);
    chk("R2 plain load", 32'h0000_2468);
  endtask

  task automatic t_fixed();
    cfg(2'd0, 2'd2, 24'd8, 24'd16);
    do_load(32'h0000_2000, 1'b0, 1'b0);
    do_step(1'b0); chk("R3 fixed step", 32'h0000_2000);
    do_step(1'b1); chk("R3 fixed boundary", 32'h0000_2000);
    do_step(1'b0); chk("R3 fixed step again", 32'h0000_2000);
  endtask

  task automatic t_incr();
    cfg(2'd1, 2'd2, 24'd100, 24'd200);
    do_load(32'h0000_0100, 1'b0, 1'b0);
    do_step(1'b0); chk("R4 incr word", 32'h0000_0104);
    do_step(1'b0); chk("R4 incr word 2", 32'h0000_0108);
    do_step(1'b1); chk("R4 incr boundary", 32'h0000_010C);
    cfg(2'd1, 2'd3, 24'd100, 24'd200);
    do_step(1'b0); chk("R4 incr dword", 32'h0000_0114);
    cfg(2'd1, 2'd1, 24'd100, 24'd200);
    do_step(1'b0); chk("R4 incr half", 32'h0000_0116);
  endtask

  task automatic t_ubs();
    cfg(2'd2, 2'd0, 24'd7, 24'd5);
    do_load(32'h0000_0040, 1'b0, 1'b0);
    do_step(1'b0); chk("R5 ubs elem", 32'h0000_0041);
    do_step(1'b0); chk("R5 ubs elem 2", 32'h0000_0042);
    do_step(1'b1); chk("R5 ubs boundary", 32'h0000_0048);
  endtask

  task automatic t_ubs_ds();
    cfg(2'd3, 2'd1, 24'd4, 24'hFFFFFA);
    do_load(32'h0000_0080, 1'b0, 1'b0);
    do_step(1'b0); chk("R6 ds elem", 32'h0000_0086);
    do_step(1'b1); chk("R6 ds boundary", 32'h0000_0082);
  endtask

  task automatic t_minus_one();
    cfg(2'd3, 2'd0, 24'hFFFFFF, 24'd0);
    do_load(32'h0000_0300, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      do_step(1'b0); chk("R7 stride -1 hold", 32'h0000_0300);
    end
  endtask

  task automatic t_replay();
    cfg(2'd2, 2'd0, 24'd0, 24'hFFFFFC);
    do_load(32'h0000_0500, 1'b0, 1'b0);
    for (int r = 0; r < 2; r++) begin
      for (int i = 1; i < 4; i++) begin
        do_step(1'b0); chk("R8 replay elem", 32'h0000_0500 + i);
      end
      do_step(1'b1); chk("R8 replay boundary", 32'h0000_0500);
    end
    for (int i = 1; i < 4; i++) do_step(1'b0);
    cfg(2'd2, 2'd0, 24'd0, 24'hFFFFF8);
    do_step(1'b1); chk("R8 step back", 32'h0000_04FC);
  endtask

  task automatic t_wrap();
    cfg(2'd3, 2'd0, 24'h7FFFFF, 24'd0);
    do_load(32'hFFFF_FFF0, 1'b0, 1'b0);
    do_step(1'b0); chk("R9 wrap positive", 32'h007F_FFF0);
    cfg(2'd3, 2'd0, 24'h800000, 24'd0);
    do_load(32'h0000_0000, 1'b0, 1'b0);
    do_step(1'b0); chk("R9 sign extend", 32'hFF80_0001);
    cfg(2'd2, 2'd0, 24'd0, 24'h800000);
    do_step(1'b1); chk("R9 ublk sign extend", 32'hFF00_0002);
  endtask

  task automatic t_idle();
    cfg(2'd3, 2'd2, 24'd12, 24'd34);
    do_load(32'h0000_7777, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R10 idle hold", 32'h0000_7777);
    end
  endtask

  task automatic t_rotate();
    cfg(2'd3, 2'd0, 24'd9, 24'hFFFFA4);
    do_load(32'd9, 1'b0, 1'b0);
    for (int k = 0; k < 100; k++) begin
      chk("R11 rotation", (k % 10) * 10 + (9 - k / 10));
      if (k < 99) do_step((k % 10) == 9);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; load_i = 1'b0; start_addr_i = '0; width_i = '0;
    mode_i = '0; data_stride_i = '0; ublk_stride_i = '0;
    elem_step_i = 1'b0; ublk_step_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_priority();
    t_fixed();
    t_incr();
    t_ubs();
    t_ubs_ds();
    t_minus_one();
    t_replay();
    t_wrap();
    t_idle();
    t_rotate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule